// File: doc/BRIEF.md
# Terminal Address Latch and Checker

This block gives a bus terminal its identity. Five hard-wired address lines and one parity line are brought in through a small synchroniser and captured while reset is held. From the moment reset is released the captured value is frozen until the next reset, whatever the wires do in the meantime. The block continuously reports the frozen address, checks that the six captured lines together carry odd parity, and flags the case where every line reads high. Because the lines have pull-ups, that all-high pattern is what disconnected wiring looks like, and it is taken as a sign that the unit has been released from its carrier.

A neighbouring command decoder presents each incoming command word with a one-cycle valid strobe. The block compares the address field of that word with the frozen address and returns a registered match one cycle later. An address field of all ones is treated as broadcast and matches any terminal. A parity fault on the captured address blocks every match, so a mis-wired terminal never answers.

Reset is synchronous and active high. Reset sequencing and the rest of command decoding belong to other blocks.

Top module: `rt_addr_guard`

## Requirements
- R1: `addr_pins[0]` is the least significant address line and `addr_pins[4]` the most significant. `term_addr_o` shows the captured lines with the same bit order.
- R2: `parity_fault_o` is 1 exactly when the six captured lines (`term_addr_o` together with the captured parity line) hold an even number of ones. It is valid from the second clock edge after reset is released.
- R3: The lines are captured only while `rst` is high. Once reset is released, `term_addr_o` stays fixed until the next reset whatever the pins do, and so do `parity_fault_o` and `released_o`.
- R4: One cycle after a cycle with `cmd_valid` high, `addr_match_o` is 1 when `cmd_word[15:11]` equals `term_addr_o` and there is no parity fault.
- R5: `released_o` is 1 exactly when all five captured address lines and the captured parity line are 1. This pattern always has even parity, so `released_o` implies `parity_fault_o`.
- R6: While the captured parity is not odd, `addr_match_o` and `bcast_o` stay 0 for every command, including broadcast.
- R7: A command whose field `cmd_word[15:11]` is 31 (all ones) matches any captured address that has good parity. `bcast_o` is then 1 in the same cycle as `addr_match_o`. `bcast_o` is 0 for any other field value.
- R8: `addr_match_o` and `bcast_o` are 0 in the cycle after a cycle with `cmd_valid` low, whatever `cmd_word` holds, and are 0 while `rst` is high.
- R9: Pins pass through SYNC_STAGES (default 2) flip-flops before capture. A pin change seen by SYNC_STAGES or fewer reset-high clock edges before release is not captured. A change held for SYNC_STAGES+1 reset-high edges is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; lines are captured while high |
| addr_pins | input | 5 | Hard-wired address lines, bit 0 least significant |
| par_pin | input | 1 | Hard-wired parity line completing odd parity |
| cmd_valid | input | 1 | Strobe marking a command word to compare |
| cmd_word | input | 16 | Command word; address field in bits 15:11 |
| term_addr_o | output | 5 | Captured terminal address |
| addr_match_o | output | 1 | Registered match for the previous strobed command |
| bcast_o | output | 1 | Match came from the broadcast field value |
| parity_fault_o | output | 1 | Captured lines do not have odd parity |
| released_o | output | 1 | All six captured lines are high |

## Verification
The bench uses the default parameters. These are a 5-bit address, a 16-bit command with the field at bit 11, two synchroniser stages and broadcast enabled. With them all 32 addresses can be swept under both parity values, so every captured pattern is reached, including the all-ones released pattern and the cases where an own address of 31 collides with the broadcast code. The two-stage depth keeps the too-late pin change a short directed case: it is checked against the change that is captured just in time. Random command fields and pin changes after release are mixed in around these directed cases.

// File: rtl/rt_addr_pkg.sv
package rt_addr_pkg;

  // How a command hit this terminal
  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_OWN   = 2'd1,
    HIT_BCAST = 2'd2
  } hit_kind_t;

  // Registered health of the captured lines
  typedef struct packed {
    logic fault;
    logic released;
  } addr_status_t;

endpackage

// File: rtl/rt_addr_sync.sv
module rt_addr_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  // The chain is not reset: it must keep tracking the pins through reset
  always_ff @(posedge clk) begin
    stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rt_addr_capture.sv
module rt_addr_capture
  import rt_addr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sync_addr,
  input  logic              sync_par,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_par,
  output addr_status_t      status
);

  localparam int LINES = ADDR_W + 1;

  logic [LINES-1:0] lines;

  // Keep loading while reset is held; the last load before release stays
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr <= sync_addr;
      lat_par  <= sync_par;
    end
  end

  assign lines = {lat_par, lat_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '{fault: 1'b0, released: 1'b0};
    end else begin
      status.fault    <= ~(^lines);
      status.released <= &lines;
    end
  end

endmodule

// File: rtl/rt_addr_compare.sv
module rt_addr_compare
  import rt_addr_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CMD_W     = 16,
  parameter int FIELD_LSB = 11,
  parameter bit BCAST_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              lat_par,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              match_o,
  output logic              bcast_o
);

  localparam logic [ADDR_W-1:0] BCAST_CODE = '1;

  logic [ADDR_W-1:0] field;
  logic              par_ok;
  hit_kind_t         hit;
  logic              unused_cmd;

  assign field      = cmd_word[FIELD_LSB +: ADDR_W];
  assign unused_cmd = ^cmd_word;
  // Parity is taken straight from the captured lines so no early command slips through
  assign par_ok     = ^{lat_par, lat_addr};

  always_comb begin
    hit = HIT_NONE;
    if (cmd_valid && par_ok) begin
      if (BCAST_EN && field == BCAST_CODE) begin
        hit = HIT_BCAST;
      end else if (field == lat_addr) begin
        hit = HIT_OWN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
      bcast_o <= 1'b0;
    end else begin
      match_o <= (hit != HIT_NONE);
      bcast_o <= (hit == HIT_BCAST);
    end
  end

endmodule

// File: rtl/rt_addr_guard.sv
module rt_addr_guard
  import rt_addr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CMD_W       = 16,
  parameter int FIELD_LSB   = 11,
  parameter int SYNC_STAGES = 2,
  parameter bit BCAST_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic              par_pin,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [ADDR_W-1:0] term_addr_o,
  output logic              addr_match_o,
  output logic              bcast_o,
  output logic              parity_fault_o,
  output logic              released_o
);

  localparam int LINES = ADDR_W + 1;

  logic [LINES-1:0]  sync_lines;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_par;
  addr_status_t      status;

  rt_addr_sync #(
    .W      (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .d   ({par_pin, addr_pins}),
    .q   (sync_lines)
  );

  rt_addr_capture #(
    .ADDR_W (ADDR_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .sync_addr (sync_lines[ADDR_W-1:0]),
    .sync_par  (sync_lines[ADDR_W]),
    .lat_addr  (lat_addr),
    .lat_par   (lat_par),
    .status    (status)
  );

  rt_addr_compare #(
    .ADDR_W    (ADDR_W),
    .CMD_W     (CMD_W),
    .FIELD_LSB (FIELD_LSB),
    .BCAST_EN  (BCAST_EN)
  ) u_compare (
    .clk       (clk),
    .rst       (rst),
    .lat_addr  (lat_addr),
    .lat_par   (lat_par),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .match_o   (addr_match_o),
    .bcast_o   (bcast_o)
  );

  assign term_addr_o    = lat_addr;
  assign parity_fault_o = status.fault;
  assign released_o     = status.released;

endmodule

// File: rtl/rt_addr_guard_chk.sv
module rt_addr_guard_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] term_addr_o,
  input logic              addr_match_o,
  input logic              bcast_o,
  input logic              parity_fault_o,
  input logic              released_o
);

  // R3
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(term_addr_o));

  // R3
  status_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> ($stable(parity_fault_o) && $stable(released_o)));

  // R5
  released_implies_fault_chk: assert property (@(posedge clk) disable iff (rst)
    released_o |-> parity_fault_o);

  // R6
  fault_blocks_match_chk: assert property (@(posedge clk) disable iff (rst)
    parity_fault_o |-> (!addr_match_o && !bcast_o));

  // R7
  bcast_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    bcast_o |-> addr_match_o);

  // R8
  no_strobe_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !addr_match_o);

endmodule

bind rt_addr_guard rt_addr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_valid      (cmd_valid),
  .term_addr_o    (term_addr_o),
  .addr_match_o   (addr_match_o),
  .bcast_o        (bcast_o),
  .parity_fault_o (parity_fault_o),
  .released_o     (released_o)
);

// File: tb/rt_addr_guard_tb.sv
module rt_addr_guard_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr_pins = '0;
  logic        par_pin = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [4:0]  term_addr_o;
  logic        addr_match_o, bcast_o, parity_fault_o, released_o;

  int n_chk = 0;
  int n_fail = 0;

  // model of the captured lines
  logic [4:0] m_addr;
  logic       m_par;

  always #2 clk = ~clk;

  rt_addr_guard u_dut (
    .clk(clk), .rst(rst), .addr_pins(addr_pins), .par_pin(par_pin),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .term_addr_o(term_addr_o),
    .addr_match_o(addr_match_o), .bcast_o(bcast_o),
    .parity_fault_o(parity_fault_o), .released_o(released_o)
  );

  function automatic logic exp_fault(input logic [4:0] a, input logic p);
    return ~(^{p, a});
  endfunction

  function automatic logic exp_match(input logic v, input logic [4:0] fld,
                                     input logic [4:0] a, input logic p);
    return v && !exp_fault(a, p) && (fld == a || fld == 5'd31);
  endfunction

  function automatic logic exp_bcast(input logic v, input logic [4:0] fld,
                                     input logic [4:0] a, input logic p);
    return exp_match(v, fld, a, p) && fld == 5'd31;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reset with given lines held for six reset-high edges; release at a negedge
  task automatic do_reset(input logic [4:0] a, input logic p);
    @(negedge clk);
    rst = 1'b1;
    addr_pins = a;
    par_pin = p;
    repeat (6) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_addr = a;
    m_par = p;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic v, input logic [4:0] fld, input logic [10:0] low);
    cmd_valid = v;
    cmd_word = {fld, low};
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R4 match", int'(addr_match_o), int'(exp_match(v, fld, m_addr, m_par)));
    check("R7 bcast", int'(bcast_o), int'(exp_bcast(v, fld, m_addr, m_par)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0017));
    // reset state of the match outputs (R8)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 match in reset", int'(addr_match_o), 0);
    check("R8 bcast in reset", int'(bcast_o), 0);

    // sweep every address under both parity values
    for (int i = 0; i < 64; i++) begin
      logic [4:0] a;
      logic p;
      a = i[4:0];
      p = i[5];
      do_reset(a, p);
      check("R1 address order", int'(term_addr_o), int'(a));
      check("R2 parity fault", int'(parity_fault_o), int'(exp_fault(a, p)));
      check("R5 released", int'(released_o), int'(&{p, a}));
      send(1'b1, a, 11'($urandom));                  // own address (R4, R6)
      send(1'b1, 5'd31, 11'($urandom));              // broadcast (R7)
      send(1'b1, a ^ 5'd1, 11'($urandom));           // neighbour
      send(1'b0, a, 11'($urandom));                  // no strobe (R8)
      send(1'b1, 5'($urandom), 11'($urandom));       // random field
      // pins move after release: ignored (R3)
      addr_pins = 5'($urandom);
      par_pin = 1'($urandom);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R3 addr held", int'(term_addr_o), int'(a));
      check("R3 fault held", int'(parity_fault_o), int'(exp_fault(a, p)));
      check("R3 released held", int'(released_o), int'(&{p, a}));
      send(1'b1, a, 11'($urandom));
    end

    // R9: late change (two reset-high edges) is not captured
    do_reset(5'd10, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    addr_pins = 5'd6;
    par_pin = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    addr_pins = 5'd9;
    par_pin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 late change ignored", int'(term_addr_o), 6);

    // R9: change held three reset-high edges is captured
    @(negedge clk);
    rst = 1'b1;
    addr_pins = 5'd6;
    repeat (6) @(posedge clk);
    @(negedge clk);
    addr_pins = 5'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 timely change captured", int'(term_addr_o), 9);

    // R8: match clears when reset is asserted again
    m_addr = 5'd9;
    m_par = 1'b1;
    cmd_valid = 1'b1;
    cmd_word = {5'd9, 11'd0};
    @(posedge clk);
    @(negedge clk);
    check("R4 match before reset", int'(addr_match_o), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 match cleared by reset", int'(addr_match_o), 0);
    cmd_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule